// File: doc/BRIEF.md
# Compare-Match General-Purpose Timer

This block is an up-counting timer peripheral with a small word-addressed register bus. A selectable tick source (one of seven single-cycle tick-enable inputs, all in the bus clock domain) is divided by a programmable prescale factor. The result advances a counter that is compared against three programmable match values. Each match, and each wrap of the counter through all ones, raises a sticky status flag. Software clears a flag by writing a one to it. A per-flag enable mask combines the flags into a single level interrupt.

Two counting modes are offered. In free-run mode the counter spans its full range. In restart mode compare 1 doubles as the period register: the counter returns to zero on the advance after it equals compare 1, and a write to compare 1 restarts the count. Counting is governed by a two-state machine. HALT moves to COUNT on a control write with the enable bit at 1. COUNT moves back to HALT on a control write with the enable bit at 0. When HALT moves to COUNT with the start-fresh bit set, the counter restarts from zero. A control write with the soft-reset bit set returns the block to its reset values but keeps the low control bits that were written in the same access.

Top module: `cmt_timer`

## Requirements
- R1: Registers are selected by word index on `bus_addr`: 0 control, 1 prescale, 2 status, 3 interrupt enable, 4, 5 and 6 compare 1, 2 and 3, 7 and 8 capture 1 and 2 (always read 0, writes ignored), 9 counter (read-only, zero-extended). Any other index reads 0.
- R2: The control bits are enable at bit 0, start-fresh mode at bit 1, source select at bits 8:6, free-run at bit 9 and soft reset at bit 15. Written bits covered by mask 0x7C14, and bit 15, are dropped and read back as 0. Every other written bit reads back as written.
- R3: A source select code k in 1..7 takes its ticks from `src_tick[k-1]`. Code 0 selects no source, so the counter does not move. Ticks on sources that are not selected have no effect.
- R4: The counter advances once for every (prescale + 1) selected ticks. The prescale register keeps the low PR_W bits of a write (PR_W defaults to 12). The prescale phase returns to zero on every counter restart.
- R5: In restart mode (bit 9 = 0), an advance taken while the counter equals compare 1 loads 0 in place of the increment.
- R6: In free-run mode the counter runs up to all ones and then wraps to 0. An advance taken from all ones sets status bit 5.
- R7: Status bits 0, 1 and 2 set on the advance that makes the counter equal compare 1, 2 and 3. Status bits 3 and 4 never set.
- R8: A write to status clears the bits among 5:0 that are written as 1; higher bits are ignored. If a flag is set and cleared in the same cycle, it stays set. The interrupt-enable register keeps only bits 5:0.
- R9: `irq` is high exactly when the timer is enabled and (status AND interrupt enable) is non-zero. It follows the registers without delay.
- R10: A write to compare 1 in restart mode sets the counter to 0. In free-run mode the same write leaves the counter unchanged.
- R11: While the timer is disabled the counter holds its value. An enable rise with bit 1 = 1 restarts the counter from 0. An enable rise with bit 1 = 0 resumes from the held value. A control write that keeps enable at 1 does not restart the counter.
- R12: Hard reset clears control, prescale, status, interrupt enable and the counter, and sets all three compares to all ones.
- R13: A control write with bit 15 set is a soft reset. Control keeps bits 8:0 of the written value (after the drop mask) and clears all its other bits. Every other register takes its hard-reset value. If the kept enable bit is 1, counting continues from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_addr | input | ADDR_W | Register word index |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the word at `bus_addr` |
| src_tick | input | 2**CS_W-1 | Single-cycle tick enables, one per clock source |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that closes its write cycle, and read data follows `bus_addr` combinationally. The bench therefore drives each access at a falling edge and reads the result at the next falling edge. The counter and the status flags change at the edge where the selected tick is high with the prescale phase complete. `irq` changes in the same cycle as the flag or enable that moves it, so every sample falls one half-cycle after the edge that caused it. The set-against-clear case drives a status write and the matching tick in one cycle and reads status one cycle later.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // register word indices
    localparam int REG_CTRL = 0;
    localparam int REG_PRE  = 1;
    localparam int REG_STAT = 2;
    localparam int REG_IEN  = 3;
    localparam int REG_CMP0 = 4;
    localparam int REG_CNT  = 9;

    // compare channels and status layout
    localparam int NCMP      = 3;
    localparam int NFLAG     = 6;
    localparam int FLAG_ROLL = 5;

    // control bit positions
    localparam int B_EN    = 0;
    localparam int B_FRESH = 1;
    localparam int CS_LO   = 6;
    localparam int B_FREE  = 9;
    localparam int B_SWR   = 15;

    localparam logic [31:0] CTRL_DROP      = 32'h0000_7C14;
    localparam logic [31:0] CTRL_SWR       = 32'h0000_8000;
    localparam logic [31:0] CTRL_EN        = 32'h0000_0001;
    localparam logic [31:0] CTRL_SOFT_KEEP = 32'h0000_01FF;

    typedef enum logic [0:0] {
        TS_HALT  = 1'b0,
        TS_COUNT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/cmt_tick.sv
module cmt_tick
    import cmt_pkg::*;
#(
    parameter int PR_W = 12,
    parameter int CS_W = 3,
    localparam int NSRC = (1 << CS_W) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_tick,
    input  logic [CS_W-1:0] clk_sel,
    input  logic [PR_W-1:0] pre_div,
    input  logic            run,
    input  logic            clr,
    output logic            adv
);

    logic [NSRC:0]   src_ext;
    logic            sel_tick;
    logic [PR_W-1:0] phase_q;
    logic            wrap;

    // code 0 maps to a constant-zero slot
    assign src_ext  = {src_tick, 1'b0};
    assign sel_tick = src_ext[clk_sel];
    assign wrap     = (phase_q >= pre_div);
    assign adv      = run && sel_tick && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (run && sel_tick) begin
            phase_q <= wrap ? '0 : phase_q + PR_W'(1);
        end
    end

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PR_W   = 12,
    parameter int CS_W   = 3,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  run,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [NFLAG-1:0]      flag_set,
    output logic                  ctrl_wr,
    output logic                  soft_rst,
    output logic                  cmp1_wr,
    output logic                  free_run,
    output logic [CS_W-1:0]       clk_sel,
    output logic [PR_W-1:0]       pre_div,
    output logic [NFLAG-1:0]      stat,
    output logic [NFLAG-1:0]      ien,
    output logic [NCMP*CNT_W-1:0] cmp_flat
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(REG_PRE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(REG_IEN);
    localparam logic [ADDR_W-1:0] A_CMP0 = ADDR_W'(REG_CMP0);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);

    // enable lives in the state machine; stored copy keeps the rest
    localparam logic [DATA_W-1:0] KEEP_WR   = ~DATA_W'(CTRL_DROP | CTRL_SWR | CTRL_EN);
    localparam logic [DATA_W-1:0] KEEP_SOFT = KEEP_WR & DATA_W'(CTRL_SOFT_KEEP);

    logic [DATA_W-1:0] ctrl_q;
    logic [PR_W-1:0]   pre_q;
    logic [NFLAG-1:0]  stat_q;
    logic [NFLAG-1:0]  ien_q;
    logic [NFLAG-1:0]  clr_mask;
    logic [CNT_W-1:0]  cmp_q [NCMP];

    assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
    assign soft_rst = ctrl_wr && bus_wdata[B_SWR];
    assign cmp1_wr  = bus_we && (bus_addr == A_CMP0);
    assign clr_mask = (bus_we && (bus_addr == A_STAT)) ? bus_wdata[NFLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (soft_rst) begin
            ctrl_q <= bus_wdata & KEEP_SOFT;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata & KEEP_WR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ien_q <= '0;
        end else if (soft_rst) begin
            pre_q <= '0;
            ien_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_PRE) pre_q <= bus_wdata[PR_W-1:0];
            if (bus_addr == A_IEN) ien_q <= bus_wdata[NFLAG-1:0];
        end
    end

    // sticky flags: a set in the same cycle overrides a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (soft_rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | flag_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCMP; i++) cmp_q[i] <= '1;
        end else if (soft_rst) begin
            for (int i = 0; i < NCMP; i++) cmp_q[i] <= '1;
        end else if (bus_we) begin
            for (int i = 0; i < NCMP; i++) begin
                if (bus_addr == ADDR_W'(REG_CMP0 + i)) cmp_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    generate
        for (genvar g = 0; g < NCMP; g++) begin : g_cmp_out
            assign cmp_flat[g*CNT_W +: CNT_W] = cmp_q[g];
        end
    endgenerate

    // capture words 7 and 8 fall to the default and read 0
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q | DATA_W'(run);
            A_PRE:   bus_rdata = DATA_W'(pre_q);
            A_STAT:  bus_rdata = DATA_W'(stat_q);
            A_IEN:   bus_rdata = DATA_W'(ien_q);
            A_CNT:   bus_rdata = DATA_W'(cnt);
            default: bus_rdata = '0;
        endcase
        for (int i = 0; i < NCMP; i++) begin
            if (bus_addr == ADDR_W'(REG_CMP0 + i)) bus_rdata = DATA_W'(cmp_q[i]);
        end
    end

    assign free_run = ctrl_q[B_FREE];
    assign clk_sel  = ctrl_q[CS_LO +: CS_W];
    assign pre_div  = pre_q;
    assign stat     = stat_q;
    assign ien      = ien_q;

endmodule

// File: rtl/cmt_core.sv
module cmt_core
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr,
    input  logic                  soft_rst,
    input  logic                  wr_en_bit,
    input  logic                  wr_fresh_bit,
    input  logic                  cmp1_wr,
    input  logic                  free_run,
    input  logic                  adv,
    input  logic [NCMP*CNT_W-1:0] cmp_flat,
    output logic                  run,
    output logic                  restart,
    output logic [CNT_W-1:0]      cnt,
    output logic [NFLAG-1:0]      flag_set
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cmp_w [NCMP];
    logic             start_fresh;
    logic             step;

    generate
        for (genvar g = 0; g < NCMP; g++) begin : g_cmp_in
            assign cmp_w[g] = cmp_flat[g*CNT_W +: CNT_W];
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_HALT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_HALT:  if (ctrl_wr && wr_en_bit)  state_d = TS_COUNT;
            TS_COUNT: if (ctrl_wr && !wr_en_bit) state_d = TS_HALT;
            default:  state_d = TS_HALT;
        endcase
    end

    assign start_fresh = (state_q == TS_HALT) && ctrl_wr && wr_en_bit && wr_fresh_bit;

    // counter next value
    always_comb begin
        cnt_d = cnt_q;
        step  = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if ((state_q == TS_COUNT) && adv) begin
            step = 1'b1;
            if (!free_run && (cnt_q == cmp_w[0])) cnt_d = '0;
            else                                  cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // outputs
    always_comb begin
        run      = (state_q == TS_COUNT);
        restart  = soft_rst || start_fresh || (cmp1_wr && !free_run);
        cnt      = cnt_q;
        flag_set = '0;
        for (int i = 0; i < NCMP; i++) begin
            flag_set[i] = step && (cnt_d == cmp_w[i]);
        end
        flag_set[FLAG_ROLL] = step && (cnt_q == '1);
    end

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PR_W   = 12,
    parameter int CS_W   = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int NSRC  = (1 << CS_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_tick,
    output logic              irq
);

    logic                  ctrl_wr, soft_rst, cmp1_wr, free_run;
    logic [CS_W-1:0]       clk_sel;
    logic [PR_W-1:0]       pre_div;
    logic [NFLAG-1:0]      stat, ien, flag_set;
    logic [NCMP*CNT_W-1:0] cmp_flat;
    logic                  run, restart, adv;
    logic [CNT_W-1:0]      cnt_q;

    cmt_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PR_W(PR_W), .CS_W(CS_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .run(run), .cnt(cnt_q), .flag_set(flag_set),
        .ctrl_wr(ctrl_wr), .soft_rst(soft_rst), .cmp1_wr(cmp1_wr), .free_run(free_run),
        .clk_sel(clk_sel), .pre_div(pre_div), .stat(stat), .ien(ien), .cmp_flat(cmp_flat)
    );

    cmt_tick #(.PR_W(PR_W), .CS_W(CS_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .clk_sel(clk_sel),
        .pre_div(pre_div), .run(run), .clr(restart), .adv(adv)
    );

    cmt_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .soft_rst(soft_rst),
        .wr_en_bit(bus_wdata[B_EN]), .wr_fresh_bit(bus_wdata[B_FRESH]),
        .cmp1_wr(cmp1_wr), .free_run(free_run), .adv(adv), .cmp_flat(cmp_flat),
        .run(run), .restart(restart), .cnt(cnt_q), .flag_set(flag_set)
    );

    assign irq = run && ((stat & ien) != '0);

endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int CS_W   = 3,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic              wd_swr,
    input logic [NFLAG-1:0]  wd_clr,
    input logic              run,
    input logic              adv,
    input logic              free_run,
    input logic [CS_W-1:0]   clk_sel,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp0,
    input logic [NFLAG-1:0]  stat,
    input logic              irq
);

    logic [NFLAG-1:0] clr_mask;
    logic             swr_now;

    assign clr_mask = (we && (addr == ADDR_W'(REG_STAT))) ? wd_clr : '0;
    assign swr_now  = we && (addr == ADDR_W'(REG_CTRL)) && wd_swr;

    a_r3_no_source_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == '0 && !we) |=> $stable(cnt));

    a_r5_restart_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv && !free_run && cnt == cmp0 && !we) |=> (cnt == '0));

    a_r6_roll_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv && cnt == '1 && !we) |=> stat[FLAG_ROLL]);

    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !swr_now |=> ((($past(stat) & ~$past(clr_mask)) & ~stat) == '0));

    a_r9_irq_needs_run_and_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (run && stat != '0));

    a_r10_cmp1_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(REG_CMP0) && !free_run) |=> (cnt == '0));

    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we) |=> $stable(cnt));

endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W), .CS_W(CS_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wd_swr(bus_wdata[cmt_pkg::B_SWR]), .wd_clr(bus_wdata[cmt_pkg::NFLAG-1:0]),
    .run(run), .adv(adv), .free_run(free_run), .clk_sel(clk_sel),
    .cnt(cnt_q), .cmp0(cmp_flat[CNT_W-1:0]), .stat(stat), .irq(irq)
);

// File: tb/cmt_timer_tb_top.sv
module cmt_timer_tb_top;

    localparam int CW = 8;
    localparam int PW = 4;
    localparam int SW = 3;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NS = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NS-1:0] tick = '0;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmt_timer #(.CNT_W(CW), .PR_W(PW), .CS_W(SW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .src_tick(tick), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = AW'(a); we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic chk_reg(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input int n, input logic [NS-1:0] m);
        repeat (n) begin
            @(negedge clk); tick = m;
            @(negedge clk); tick = '0;
        end
    endtask

    function automatic logic [31:0] cfg(input bit en, input bit fr, input int cs, input bit free);
        return 32'(en) | (32'(fr) << 1) | (32'(cs) << 6) | (32'(free) << 9);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk_reset_vals(input string req);
        chk_reg(req, 0, 32'h0);
        chk_reg(req, 1, 32'h0);
        chk_reg(req, 2, 32'h0);
        chk_reg(req, 3, 32'h0);
        for (int i = 4; i <= 6; i++) chk_reg(req, i, 32'hFF);
        chk_reg(req, 9, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v0;
        do_reset();

        // R12 hard reset values, R1 capture and unmapped words
        chk_reset_vals("R12 hard reset");
        chk_reg("R1 capture1 reads 0", 7, 32'h0);
        chk_reg("R1 capture2 reads 0", 8, 32'h0);
        chk_reg("R1 unmapped word", 10, 32'h0);
        check("R9 irq after reset", 32'(irq), 32'h0);

        // R2 control drop mask
        wr(0, 32'h0000_7FFE);
        chk_reg("R2 control drop mask", 0, 32'h0000_03EA);
        wr(0, 32'h0);
        wr(7, 32'h55);
        chk_reg("R1 capture write ignored", 7, 32'h0);

        // R8 interrupt-enable width
        wr(3, 32'hFFFF_FFFF);
        chk_reg("R8 ien width", 3, 32'h3F);
        wr(3, 32'h0);

        // R3 R4 source and prescale sweep
        for (int cs = 0; cs < 8; cs++) begin
            for (int pr = 0; pr < 4; pr++) begin
                logic [NS-1:0] sel;
                sel = (cs == 0) ? '0 : NS'(1 << (cs - 1));
                wr(0, 32'h0);
                wr(1, 32'(pr));
                wr(0, cfg(1, 1, cs, 1));
                pulse(6, sel);
                pulse(3, ~sel);
                chk_reg($sformatf("R3 R4 cs=%0d pr=%0d", cs, pr), 9,
                        (cs == 0) ? 32'h0 : 32'(6 / (pr + 1)));
            end
        end
        wr(1, 32'hFFF3);
        chk_reg("R4 prescale width", 1, 32'h3);

        // R11 hold while disabled, resume and fresh start
        wr(0, cfg(0, 0, 1, 1));
        rd(9, v0);
        pulse(4, 7'h01);
        chk_reg("R11 held while disabled", 9, v0);
        wr(1, 32'h0);
        wr(0, cfg(1, 0, 1, 1));
        chk_reg("R11 resume keeps value", 9, v0);
        pulse(2, 7'h01);
        chk_reg("R11 resume counts on", 9, v0 + 2);
        wr(0, cfg(0, 0, 1, 1));
        wr(0, cfg(1, 1, 1, 1));
        chk_reg("R11 fresh start", 9, 32'h0);

        // R5 R7 restart mode period
        wr(0, 32'h0);
        wr(2, 32'h3F);
        wr(4, 32'd5);
        wr(0, cfg(1, 1, 1, 0));
        for (int k = 1; k <= 14; k++) begin
            pulse(1, 7'h01);
            chk_reg($sformatf("R5 restart count k=%0d", k), 9, 32'(k % 6));
            if (k == 4) chk_reg("R7 compare1 not yet", 2, 32'h0);
            if (k == 5) chk_reg("R7 compare1 flag", 2, 32'h1);
        end

        // R10 compare-1 write restart
        wr(4, 32'd9);
        chk_reg("R10 restart-mode write zeroes", 9, 32'h0);
        pulse(3, 7'h01);
        wr(0, cfg(1, 1, 1, 1));
        chk_reg("R11 no restart when enable stays", 9, 32'd3);
        wr(4, 32'd20);
        chk_reg("R10 free-run write keeps count", 9, 32'd3);

        // R6 R7 free-run wrap and flags
        wr(2, 32'h3F);
        wr(5, 32'd10);
        wr(0, 32'h0);
        wr(0, cfg(1, 1, 1, 1));
        pulse(10, 7'h01);
        chk_reg("R7 compare2 flag", 2, 32'h02);
        pulse(245, 7'h01);
        chk_reg("R6 reaches all ones", 9, 32'hFF);
        chk_reg("R7 flags before wrap", 2, 32'h07);
        pulse(1, 7'h01);
        chk_reg("R6 wraps to 0", 9, 32'h0);
        chk_reg("R6 rollover flag", 2, 32'h27);

        // R8 write-one-to-clear
        wr(2, 32'h02);
        chk_reg("R8 w1c one bit", 2, 32'h25);
        wr(2, 32'hFFFF_FF00);
        chk_reg("R8 high bits ignored", 2, 32'h25);

        // R9 interrupt output
        wr(3, 32'h20);
        check("R9 irq rollover enabled", 32'(irq), 32'h1);
        wr(3, 32'h01);
        check("R9 irq compare1 enabled", 32'(irq), 32'h1);
        wr(3, 32'h02);
        check("R9 irq masked", 32'(irq), 32'h0);
        wr(3, 32'h20);
        wr(0, cfg(0, 0, 1, 1));
        check("R9 irq low when disabled", 32'(irq), 32'h0);
        wr(0, cfg(1, 0, 1, 1));
        check("R9 irq back when enabled", 32'(irq), 32'h1);
        wr(2, 32'h20);
        check("R9 irq after clear", 32'(irq), 32'h0);

        // R8 set wins over clear in the same cycle
        wr(0, 32'h0);
        wr(2, 32'h3F);
        wr(6, 32'd3);
        wr(0, cfg(1, 1, 1, 1));
        pulse(2, 7'h01);
        @(negedge clk);
        addr = AW'(2); we = 1'b1; wdata = 32'h04; tick = 7'h01;
        @(negedge clk);
        we = 1'b0; wdata = '0; tick = '0;
        chk_reg("R8 set wins count", 9, 32'd3);
        chk_reg("R8 set wins over clear", 2, 32'h04);

        // R13 soft reset
        wr(1, 32'd5);
        wr(3, 32'h3F);
        wr(4, 32'd7);
        wr(0, cfg(1, 1, 2, 1) | 32'h0000_8008 | 32'h0001_0000);
        chk_reg("R13 control kept bits", 0, 32'h0000_008B);
        chk_reg("R13 prescale cleared", 1, 32'h0);
        chk_reg("R13 status cleared", 2, 32'h0);
        chk_reg("R13 ien cleared", 3, 32'h0);
        for (int i = 4; i <= 6; i++) chk_reg("R13 compare all ones", i, 32'hFF);
        chk_reg("R13 counter cleared", 9, 32'h0);
        pulse(3, 7'h02);
        chk_reg("R13 still counting", 9, 32'd3);

        // R12 hard reset from a busy state
        do_reset();
        chk_reset_vals("R12 second hard reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule